// File: doc/BRIEF.md
# USB Standard Control Request Handshake Policy

This block sits beside the packet engine of a full-speed USB device controller and decides how each control transfer is answered. The packet engine hands over a decoded setup stage (request type, request code, value, index and length) as a one-cycle pulse. Later it sends a one-cycle pulse when the status stage arrives. The block answers every status pulse with exactly one handshake choice: ACK, NAK or STALL.

Requests that the controller completes by itself are answered directly and never reach software. The block passes configuration, interface and descriptor requests, and every non-standard request, to software with a strobe that carries the latched request fields. It rejects feature requests with an illegal selector, and any request for a non-zero alternate setting. A hold mode lets software delay the completion of configuration and interface changes. While the hold is armed, those requests are answered with NAK until software writes a one-shot release.

Two control bits are written through a tiny register port. Bit 0 of the write data arms the hold mode and bit 1 grants the release. Both bits are write-1-to-set. The current value of each bit is visible on an output.

Top module: `usbrq_policy`

## Requirements
- R1: A standard request (request type bits 6:5 equal 0) with code GET_STATUS=0, SET_ADDRESS=5, GET_CONFIGURATION=8, GET_INTERFACE=10 or SYNCH_FRAME=12 is answered with ACK and raises no forward strobe.
- R2: GET_DESCRIPTOR=6, SET_DESCRIPTOR=7, SET_CONFIGURATION=9 and SET_INTERFACE=11 with alternate setting 0 raise fwd_strobe for exactly one cycle, in the cycle after setup_valid, with the request fields on the fwd outputs. GET_DESCRIPTOR and SET_DESCRIPTOR are answered with ACK.
- R3: CLEAR_FEATURE=1 and SET_FEATURE=3 are answered with ACK only for these selector/recipient pairs: selector 0 with recipient endpoint (type bits 4:0 = 2), and selectors 1 or 2 with recipient device (type bits 4:0 = 0). All other pairs get STALL. Feature requests are not forwarded.
- R4: SET_INTERFACE with a non-zero value field (alternate setting) is answered with STALL and is not forwarded.
- R5: While the mode bit is 0, SET_CONFIGURATION and legal SET_INTERFACE are answered with ACK.
- R6: While the mode bit is 1, SET_CONFIGURATION and legal SET_INTERFACE are answered with NAK on every status pulse while the release bit is 0, and with ACK once it is 1.
- R7: When a held request is answered with ACK, the release bit returns to 0 on that same clock edge. The next held request is therefore answered with NAK again.
- R8: Both control bits reset to 0. A register write with wdata bit 0 set sets the mode bit, and one with wdata bit 1 set sets the release bit. A written 0 leaves a bit unchanged. Only the hardware clear of R7 lowers the release bit, and nothing lowers the mode bit.
- R9: An unassigned standard code (for example 2, 4, 13 or above) is answered with STALL. So is a status pulse that arrives before any setup since reset.
- R10: hs_valid is 1 for exactly the cycle after each status_pulse, and is 0 otherwise. hs_code then carries ACK=1, NAK=2 or STALL=3, and it is 0 while hs_valid is 0.
- R11: A request with a non-standard type (type bits 6:5 not 0) is forwarded and answered with ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | One-cycle pulse: a decoded setup stage is present |
| req_type | input | 8 | Request type byte |
| req_code | input | 8 | Request code byte |
| req_value | input | 16 | Value field |
| req_index | input | 16 | Index field |
| req_length | input | 16 | Length field |
| status_pulse | input | 1 | One-cycle pulse: status stage reached, a handshake is needed |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 sets the hold mode, bit 1 sets the release |
| ctl_mode | output | 1 | Current hold-mode bit |
| ctl_release | output | 1 | Current release bit |
| hs_valid | output | 1 | Handshake choice valid |
| hs_code | output | 2 | Handshake choice: 1 ACK, 2 NAK, 3 STALL |
| fwd_strobe | output | 1 | One-cycle strobe: request passed to software |
| fwd_type | output | 8 | Forwarded request type |
| fwd_code | output | 8 | Forwarded request code |
| fwd_value | output | 16 | Forwarded value |
| fwd_index | output | 16 | Forwarded index |
| fwd_length | output | 16 | Forwarded length |

## Verification
The bench builds the block with its default parameters: 8-bit type and code fields, 16-bit value fields, and the self-clearing release variant. That variant is the only one in which R7 can be observed. With 16-bit value fields, a selector value with its upper byte set can be sent to check that it is rejected. Random stimulus covers all codes 0 to 15, all four recipients and values 0 to 3. It mixes in occasional register writes, so held requests are seen in both modes and with the release bit in both states.

// File: rtl/usbrq_pkg.sv
package usbrq_pkg;

   typedef enum logic [1:0] {
      HS_NONE  = 2'd0,
      HS_ACK   = 2'd1,
      HS_NAK   = 2'd2,
      HS_STALL = 2'd3
   } hs_e;

   localparam logic [7:0] RQ_GET_STATUS   = 8'd0;
   localparam logic [7:0] RQ_CLR_FEATURE  = 8'd1;
   localparam logic [7:0] RQ_SET_FEATURE  = 8'd3;
   localparam logic [7:0] RQ_SET_ADDRESS  = 8'd5;
   localparam logic [7:0] RQ_GET_DESC     = 8'd6;
   localparam logic [7:0] RQ_SET_DESC     = 8'd7;
   localparam logic [7:0] RQ_GET_CONFIG   = 8'd8;
   localparam logic [7:0] RQ_SET_CONFIG   = 8'd9;
   localparam logic [7:0] RQ_GET_IFACE    = 8'd10;
   localparam logic [7:0] RQ_SET_IFACE    = 8'd11;
   localparam logic [7:0] RQ_SYNCH_FRAME  = 8'd12;

   localparam logic [4:0] RCP_DEVICE   = 5'd0;
   localparam logic [4:0] RCP_ENDPOINT = 5'd2;

endpackage

// File: rtl/usbrq_classify.sv
module usbrq_classify
   import usbrq_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int VAL_W  = 16
) (
   input  logic [6:0]        req_type_lo,
   input  logic [CODE_W-1:0] req_code,
   input  logic [VAL_W-1:0]  req_value,
   output logic              cls_fwd,
   output logic              cls_held,
   output logic              cls_stall
);

   logic       is_std;
   logic [4:0] recip;
   logic       feat_ok;

   assign is_std = (req_type_lo[6:5] == 2'b00);
   assign recip  = req_type_lo[4:0];

   always_comb begin
      feat_ok = 1'b0;
      if (req_value == VAL_W'(0))      feat_ok = (recip == RCP_ENDPOINT);
      else if (req_value == VAL_W'(1)) feat_ok = (recip == RCP_DEVICE);
      else if (req_value == VAL_W'(2)) feat_ok = (recip == RCP_DEVICE);
   end

   always_comb begin
      cls_fwd   = 1'b0;
      cls_held  = 1'b0;
      cls_stall = 1'b0;
      if (!is_std) begin
         cls_fwd = 1'b1;
      end else begin
         case (req_code)
            CODE_W'(RQ_GET_STATUS), CODE_W'(RQ_SET_ADDRESS), CODE_W'(RQ_GET_CONFIG),
            CODE_W'(RQ_GET_IFACE), CODE_W'(RQ_SYNCH_FRAME): ;
            CODE_W'(RQ_CLR_FEATURE), CODE_W'(RQ_SET_FEATURE): cls_stall = !feat_ok;
            CODE_W'(RQ_GET_DESC), CODE_W'(RQ_SET_DESC):      cls_fwd = 1'b1;
            CODE_W'(RQ_SET_CONFIG): begin
               cls_fwd  = 1'b1;
               cls_held = 1'b1;
            end
            CODE_W'(RQ_SET_IFACE): begin
               if (req_value != VAL_W'(0)) begin
                  cls_stall = 1'b1;
               end else begin
                  cls_fwd  = 1'b1;
                  cls_held = 1'b1;
               end
            end
            default: cls_stall = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/usbrq_ctl_regs.sv
module usbrq_ctl_regs #(
   parameter bit REL_AUTOCLR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [1:0] wdata,
   input  logic       rel_consume,
   output logic       mode_q,
   output logic       rel_q
);

   logic rel_clr;

   generate
      if (REL_AUTOCLR) begin : g_autoclr
         assign rel_clr = rel_consume;
      end else begin : g_sticky
         assign rel_clr = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         rel_q  <= 1'b0;
      end else begin
         if (wr && wdata[0]) mode_q <= 1'b1;
         if (wr && wdata[1])  rel_q <= 1'b1;
         else if (rel_clr)    rel_q <= 1'b0;
      end
   end

   a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q |=> mode_q);

   a_r8_rel_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_q && !rel_consume && !(wr && wdata[1])) |=> rel_q);

   a_r8_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata == 2'b11) |=> (mode_q && rel_q));

endmodule

// File: rtl/usbrq_policy.sv
module usbrq_policy
   import usbrq_pkg::*;
#(
   parameter int TYPE_W      = 8,
   parameter int CODE_W      = 8,
   parameter int VAL_W       = 16,
   parameter bit REL_AUTOCLR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              setup_valid,
   input  logic [TYPE_W-1:0] req_type,
   input  logic [CODE_W-1:0] req_code,
   input  logic [VAL_W-1:0]  req_value,
   input  logic [VAL_W-1:0]  req_index,
   input  logic [VAL_W-1:0]  req_length,
   input  logic              status_pulse,
   input  logic              reg_wr,
   input  logic [1:0]        reg_wdata,
   output logic              ctl_mode,
   output logic              ctl_release,
   output logic              hs_valid,
   output logic [1:0]        hs_code,
   output logic              fwd_strobe,
   output logic [TYPE_W-1:0] fwd_type,
   output logic [CODE_W-1:0] fwd_code,
   output logic [VAL_W-1:0]  fwd_value,
   output logic [VAL_W-1:0]  fwd_index,
   output logic [VAL_W-1:0]  fwd_length
);

   generate
      if (TYPE_W != 8) begin : g_bad_type
         $error("usbrq_policy: TYPE_W must be 8");
      end
      if (CODE_W < 4) begin : g_bad_code
         $error("usbrq_policy: CODE_W must be at least 4");
      end
      if (VAL_W < 2) begin : g_bad_val
         $error("usbrq_policy: VAL_W must be at least 2");
      end
   endgenerate

   logic c_fwd, c_held, c_stall;
   logic live_q, held_q, stall_q;
   logic rel_consume;
   hs_e  hs_next;

   usbrq_classify #(.CODE_W(CODE_W), .VAL_W(VAL_W)) u_cls (
      .req_type_lo (req_type[6:0]),
      .req_code    (req_code),
      .req_value   (req_value),
      .cls_fwd     (c_fwd),
      .cls_held    (c_held),
      .cls_stall   (c_stall)
   );

   usbrq_ctl_regs #(.REL_AUTOCLR(REL_AUTOCLR)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (reg_wr),
      .wdata       (reg_wdata),
      .rel_consume (rel_consume),
      .mode_q      (ctl_mode),
      .rel_q       (ctl_release)
   );

   always_comb begin
      if (!live_q || stall_q)               hs_next = HS_STALL;
      else if (held_q && ctl_mode && !ctl_release) hs_next = HS_NAK;
      else                                  hs_next = HS_ACK;
   end

   assign rel_consume = status_pulse && live_q && !stall_q && held_q && ctl_mode && ctl_release;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q     <= 1'b0;
         held_q     <= 1'b0;
         stall_q    <= 1'b0;
         fwd_strobe <= 1'b0;
         fwd_type   <= '0;
         fwd_code   <= '0;
         fwd_value  <= '0;
         fwd_index  <= '0;
         fwd_length <= '0;
         hs_valid   <= 1'b0;
         hs_code    <= HS_NONE;
      end else begin
         fwd_strobe <= setup_valid && c_fwd;
         if (setup_valid) begin
            live_q     <= 1'b1;
            held_q     <= c_held;
            stall_q    <= c_stall;
            fwd_type   <= req_type;
            fwd_code   <= req_code;
            fwd_value  <= req_value;
            fwd_index  <= req_index;
            fwd_length <= req_length;
         end
         hs_valid <= status_pulse;
         hs_code  <= status_pulse ? hs_next : HS_NONE;
      end
   end

   a_r10_hs_follows: assert property (@(posedge clk) disable iff (!rst_n)
      status_pulse |=> hs_valid);

   a_r10_hs_only_after: assert property (@(posedge clk) disable iff (!rst_n)
      !status_pulse |=> (!hs_valid && hs_code == HS_NONE));

   a_r2_fwd_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
      !setup_valid |=> !fwd_strobe);

   a_r3_stall_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (status_pulse && live_q && stall_q) |=> (hs_code == HS_STALL));

   a_r5_auto_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (status_pulse && live_q && !stall_q && !ctl_mode) |=> (hs_code == HS_ACK));

   a_r6_nak_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (status_pulse && live_q && held_q && ctl_mode && !ctl_release) |=> (hs_code == HS_NAK));

   a_r7_release_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_consume && !(reg_wr && reg_wdata[1])) |=> (!ctl_release && hs_code == HS_ACK));

   a_r9_no_request: assert property (@(posedge clk) disable iff (!rst_n)
      (status_pulse && !live_q) |=> (hs_code == HS_STALL));

endmodule

// File: tb/usbrq_policy_test.sv
`timescale 1ns/1ps
module usbrq_policy_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        setup_valid = 1'b0;
   logic [7:0]  req_type = '0;
   logic [7:0]  req_code = '0;
   logic [15:0] req_value = '0;
   logic [15:0] req_index = '0;
   logic [15:0] req_length = '0;
   logic        status_pulse = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_wdata = '0;
   logic        ctl_mode, ctl_release, hs_valid, fwd_strobe;
   logic [1:0]  hs_code;
   logic [7:0]  fwd_type, fwd_code;
   logic [15:0] fwd_value, fwd_index, fwd_length;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit m_mode = 1'b0;
   bit m_rel = 1'b0;

   always #2.5 clk = ~clk;

   usbrq_policy uut (
      .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid),
      .req_type(req_type), .req_code(req_code), .req_value(req_value),
      .req_index(req_index), .req_length(req_length),
      .status_pulse(status_pulse), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .ctl_mode(ctl_mode), .ctl_release(ctl_release),
      .hs_valid(hs_valid), .hs_code(hs_code), .fwd_strobe(fwd_strobe),
      .fwd_type(fwd_type), .fwd_code(fwd_code), .fwd_value(fwd_value),
      .fwd_index(fwd_index), .fwd_length(fwd_length)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // 0 internal, 1 forward, 2 held+forward, 3 stall
   function automatic int kind(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v);
      logic [4:0] rc = t[4:0];
      bit ok;
      if (t[6:5] != 2'b00) return 1;
      case (c)
         8'd0, 8'd5, 8'd8, 8'd10, 8'd12: return 0;
         8'd1, 8'd3: begin
            ok = (v == 16'd0 && rc == 5'd2) || ((v == 16'd1 || v == 16'd2) && rc == 5'd0);
            return ok ? 0 : 3;
         end
         8'd6, 8'd7: return 1;
         8'd9: return 2;
         8'd11: return (v == 16'd0) ? 2 : 3;
         default: return 3;
      endcase
   endfunction

   function automatic int exp_hs(input int k);
      if (k == 3) return 3;
      if (k == 2 && m_mode && !m_rel) return 2;
      return 1;
   endfunction

   task automatic wr_reg(input logic [1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
      if (d[0]) m_mode = 1'b1;
      if (d[1]) m_rel = 1'b1;
      chk("R8 mode bit", ctl_mode, m_mode);
      chk("R8 release bit", ctl_release, m_rel);
   endtask

   task automatic do_status(input int k, input string tag);
      int e = exp_hs(k);
      @(negedge clk);
      status_pulse = 1'b1;
      @(negedge clk);
      status_pulse = 1'b0;
      chk({tag, " R10 hs_valid"}, hs_valid, 1);
      chk({tag, " handshake"}, hs_code, e);
      if (k == 2 && m_mode && m_rel) m_rel = 1'b0;
      chk("R7 release after handshake", ctl_release, m_rel);
      @(negedge clk);
      chk("R10 hs_valid drops", hs_valid, 0);
      chk("R10 hs_code idle", hs_code, 0);
   endtask

   task automatic do_setup(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v,
                           input string tag);
      int k = kind(t, c, v);
      logic [15:0] ix = 16'(($urandom % 65536));
      logic [15:0] ln = 16'(($urandom % 65536));
      @(negedge clk);
      setup_valid = 1'b1;
      req_type = t; req_code = c; req_value = v; req_index = ix; req_length = ln;
      @(negedge clk);
      setup_valid = 1'b0;
      chk({tag, " R2 fwd_strobe"}, fwd_strobe, (k == 1 || k == 2) ? 1 : 0);
      if (k == 1 || k == 2) begin
         chk("R2 fwd_type", fwd_type, t);
         chk("R2 fwd_code", fwd_code, c);
         chk("R2 fwd_value", fwd_value, v);
         chk("R2 fwd_index", fwd_index, ix);
         chk("R2 fwd_length", fwd_length, ln);
      end
      @(negedge clk);
      chk("R2 fwd_strobe one cycle", fwd_strobe, 0);
   endtask

   task automatic req(input logic [7:0] t, input logic [7:0] c, input logic [15:0] v,
                      input string tag);
      do_setup(t, c, v, tag);
      do_status(kind(t, c, v), tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7741));
      repeat (3) @(negedge clk);
      chk("R8 reset mode", ctl_mode, 0);
      chk("R8 reset release", ctl_release, 0);
      chk("R10 reset hs_valid", hs_valid, 0);
      chk("R2 reset fwd_strobe", fwd_strobe, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: status before any setup
      @(negedge clk); status_pulse = 1'b1;
      @(negedge clk); status_pulse = 1'b0;
      chk("R9 no request stall", hs_code, 3);

      // R1 internal requests
      req(8'h80, 8'd0, 16'd0, "R1 get_status");
      req(8'h00, 8'd5, 16'd9, "R1 set_address");
      req(8'h80, 8'd8, 16'd0, "R1 get_config");
      req(8'h81, 8'd10, 16'd0, "R1 get_iface");
      req(8'h82, 8'd12, 16'd0, "R1 synch_frame");
      // R3 feature selectors
      req(8'h02, 8'd1, 16'd0, "R3 halt endpoint");
      req(8'h00, 8'd3, 16'd1, "R3 wakeup device");
      req(8'h00, 8'd3, 16'd2, "R3 test device");
      req(8'h00, 8'd3, 16'd0, "R3 halt on device");
      req(8'h02, 8'd3, 16'd1, "R3 wakeup on endpoint");
      req(8'h00, 8'd1, 16'd3, "R3 selector 3");
      req(8'h00, 8'd3, 16'h0101, "R3 wide selector");
      // R4 alternate setting
      req(8'h01, 8'd11, 16'd1, "R4 alt 1");
      // R2 descriptors
      req(8'h80, 8'd6, 16'h0100, "R2 get_desc");
      req(8'h00, 8'd7, 16'h0200, "R2 set_desc");
      // R5 auto ack
      req(8'h00, 8'd9, 16'd1, "R5 set_config");
      req(8'h01, 8'd11, 16'd0, "R5 set_iface");
      // R9 unknown codes
      req(8'h00, 8'd2, 16'd0, "R9 code 2");
      req(8'h00, 8'd13, 16'd0, "R9 code 13");
      // R11 non-standard
      req(8'h40, 8'd2, 16'd5, "R11 vendor");
      req(8'hA1, 8'd9, 16'd0, "R11 class");
      // R8 zero writes
      wr_reg(2'b00);
      // R6 / R7 hold
      wr_reg(2'b01);
      wr_reg(2'b00);
      do_setup(8'h00, 8'd9, 16'd1, "R6 held");
      do_status(2, "R6 nak 1");
      do_status(2, "R6 nak 2");
      wr_reg(2'b10);
      wr_reg(2'b00);
      do_status(2, "R6 release ack");
      req(8'h01, 8'd11, 16'd0, "R7 rehold");
      wr_reg(2'b10);
      req(8'h00, 8'd5, 16'd3, "R7 unheld keeps release");
      req(8'h01, 8'd11, 16'd0, "R7 consume");

      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [7:0] t;
         logic [7:0] c;
         logic [15:0] v;
         int r = $urandom % 16;
         t = {1'b0, (r == 0) ? 2'b01 : 2'b00, 3'b000, 2'($urandom % 4)};
         c = 8'($urandom % 16);
         v = 16'($urandom % 4);
         if ($urandom % 5 == 0) wr_reg(2'($urandom % 4));
         req(t, c, v, "R1 random");
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule